// File: doc/BRIEF.md
# Single-Pulse Test Clock Gate

This block drives a differential clock pair (true and complement) from a source clock. It is meant for test and burn-in work. In normal operation the pair follows the source clock. When software sets a test-mode bit, the pair is parked with true low and complement high. While parked, each rising transition of a software trigger bit releases exactly one full source-clock cycle on the pair. The block never changes the clock frequency. An auxiliary fixed-rate clock passes straight through and is not affected by the test mode.

Software reaches the block through a small parallel register port, which stands in for a serial management bus. The port sits in its own configuration clock domain. A write-enable byte guards the control byte. The mode and trigger bits cross into the source-clock domain through two-flop synchronizers.

Edge detection on the trigger runs in the source-clock domain. The enable that gates the output is updated only while the source clock is low. Because of this, entering the test mode, leaving it, and starting or ending a pulse never produce a runt phase. The hardware never clears the trigger bit. To obtain the next pulse, software clears the bit and then sets it again.

Top module: `spTestClkGate`

## Requirements
- R1: After reset, the write-enable byte (address 0) and the control byte (address 8) both read as 0, and the differential pair follows the source clock.
- R2: Bit 0 of address 0 is the write-enable bit, and a write to address 0 always updates it. A write to address 8 while that bit is 0 leaves address 8 unchanged.
- R3: At address 8, bit 7 is the trigger and bit 6 is the test-mode enable. Bits 5:0 always read 0.
- R4: With the test mode off, the true output toggles once per source-clock period, and the complement output is always the inverse of the true output.
- R5: With the test mode on and no pulse in progress, the true output stays at 0 and the complement output stays at 1.
- R6: A 0-to-1 transition of the trigger while the test mode is on yields exactly one pulse. The pulse is high for half a source period, followed by a low phase, which matches the source clock's duty and period.
- R7: Leaving the trigger at 1 yields no further pulses. Clearing the trigger and setting it again yields exactly one more pulse.
- R8: The hardware never clears the trigger bit. Reading address 8 returns the trigger and mode bits exactly as written.
- R9: The auxiliary clock output equals the auxiliary clock input whether the test mode is on or off.
- R10: The output gate opens or closes only at a falling edge of the source clock, so the true output never shows a partial high phase.
- R11: A trigger rise that happens while the test mode is off, or while a pulse is in progress, is dropped and not queued. In particular, turning the test mode on while the trigger is already 1 yields no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Configuration register port clock |
| srcClk | input | 1 | Source clock to be gated |
| auxClkIn | input | 1 | Auxiliary fixed-rate clock input |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| clkOutT | output | 1 | Differential clock, true leg |
| clkOutC | output | 1 | Differential clock, complement leg |
| auxClkOut | output | 1 | Auxiliary clock output |

## Verification
The pair is checked in four situations:
- **Free running:** the edge count over a fixed window equals the number of source periods, which confirms that no cycles are swallowed.
- **Parked:** that same window must contain zero rising edges, which separates a correctly parked pair from a leaky gate.
- **Armed trigger:** each single pulse is timed with its rising and falling timestamps, which separates a full-period pulse from a runt, a double pulse, or no pulse.
- **Held trigger:** a trigger left at 1, and a trigger that was already high when the mode was entered, must both produce no pulse, which separates true edge detection from level sensing.

// File: rtl/spTestClkPkg.sv
package spTestClkPkg;

  // Strobes from control to datapath, sampled by the datapath in the low phase
  typedef struct packed {
    logic runFree;  // normal operation: gate follows source clock
    logic fire;     // release one cycle while parked
  } gateStrobeT;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_FIRE = 2'd1,
    PS_TAIL = 2'd2
  } pulseStateT;

endpackage

// File: rtl/spTestClkRegs.sv
module spTestClkRegs #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WEN_ADDR  = 0,
  parameter int CTRL_ADDR = 8,
  parameter int WEN_BIT   = 0,
  parameter int TRIG_BIT  = 7,
  parameter int MODE_BIT  = 6
) (
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wenBit,
  output logic              trigBit,
  output logic              modeBit
);

  localparam logic [ADDR_W-1:0] WEN_A  = ADDR_W'(WEN_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic wenHit;
  logic ctrlHit;

  assign wenHit  = wrEn && (wrAddr == WEN_A);
  assign ctrlHit = wrEn && (wrAddr == CTRL_A) && wenBit;

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      wenBit  <= 1'b0;
      trigBit <= 1'b0;
      modeBit <= 1'b0;
    end else begin
      if (wenHit) begin
        wenBit <= wrData[WEN_BIT];
      end
      if (ctrlHit) begin
        trigBit <= wrData[TRIG_BIT];
        modeBit <= wrData[MODE_BIT];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == WEN_A) begin
      rdData[WEN_BIT] = wenBit;
    end else if (rdAddr == CTRL_A) begin
      rdData[TRIG_BIT] = trigBit;
      rdData[MODE_BIT] = modeBit;
    end
  end

endmodule

// File: rtl/spTestClkCtrl.sv
module spTestClkCtrl
  import spTestClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       rstN,
  input  logic       trigAsync,
  input  logic       modeAsync,
  output gateStrobeT strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] trigSync;
  logic [SYNC_STAGES-1:0] modeSync;
  logic                   trigPrev;
  logic                   trigRise;
  pulseStateT             pState;
  pulseStateT             pNext;

  generate
    if (SYNC_STAGES < 2) begin : gBadSync
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      trigSync <= '0;
      modeSync <= '0;
      trigPrev <= 1'b0;
      pState   <= PS_IDLE;
    end else begin
      trigSync <= {trigSync[LAST-1:0], trigAsync};
      modeSync <= {modeSync[LAST-1:0], modeAsync};
      trigPrev <= trigSync[LAST];
      pState   <= pNext;
    end
  end

  // Rise recognized only in idle with mode on; otherwise it is dropped
  assign trigRise = trigSync[LAST] & ~trigPrev;

  always_comb begin
    pNext = pState;
    unique case (pState)
      PS_IDLE: if (trigRise && modeSync[LAST]) pNext = PS_FIRE;
      PS_FIRE: pNext = PS_TAIL;
      PS_TAIL: pNext = PS_IDLE;
      default: pNext = PS_IDLE;
    endcase
  end

  assign strobes.fire    = (pState == PS_FIRE);
  assign strobes.runFree = ~modeSync[LAST];

endmodule

// File: rtl/spTestClkPath.sv
module spTestClkPath
  import spTestClkPkg::*;
(
  input  logic       srcClk,
  input  logic       rstN,
  input  logic       auxClkIn,
  input  gateStrobeT strobes,
  output logic       gateOn,
  output logic       clkOutT,
  output logic       clkOutC,
  output logic       auxClkOut
);

  // Gate enable only changes while srcClk is low
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) begin
      gateOn <= 1'b0;
    end else begin
      gateOn <= strobes.runFree | strobes.fire;
    end
  end

  assign clkOutT   = srcClk & gateOn;
  assign clkOutC   = ~clkOutT;
  assign auxClkOut = auxClkIn;

endmodule

// File: rtl/spTestClkGate.sv
module spTestClkGate
  import spTestClkPkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              cfgClk,
  input  logic              srcClk,
  input  logic              auxClkIn,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              clkOutT,
  output logic              clkOutC,
  output logic              auxClkOut
);

  gateStrobeT strobes;
  logic       wenBit;
  logic       trigBit;
  logic       modeBit;
  logic       gateOn;
  logic       fire;
  logic       runFree;

  spTestClkRegs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .cfgClk (cfgClk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wenBit (wenBit),
    .trigBit(trigBit),
    .modeBit(modeBit)
  );

  spTestClkCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .srcClk   (srcClk),
    .rstN     (rstN),
    .trigAsync(trigBit),
    .modeAsync(modeBit),
    .strobes  (strobes)
  );

  spTestClkPath u_path (
    .srcClk   (srcClk),
    .rstN     (rstN),
    .auxClkIn (auxClkIn),
    .strobes  (strobes),
    .gateOn   (gateOn),
    .clkOutT  (clkOutT),
    .clkOutC  (clkOutC),
    .auxClkOut(auxClkOut)
  );

  assign fire    = strobes.fire;
  assign runFree = strobes.runFree;

endmodule

// File: rtl/spTestClkGateChk.sv
module spTestClkGateChk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 8,
  parameter int TRIG_BIT  = 7,
  parameter int MODE_BIT  = 6
) (
  input logic              cfgClk,
  input logic              srcClk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              wenBit,
  input logic              trigBit,
  input logic              modeBit,
  input logic              fire,
  input logic              runFree,
  input logic              gateOn
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] LIVE_MASK =
    DATA_W'((1 << TRIG_BIT) | (1 << MODE_BIT));

  AST_RSVD_ZERO: assert property (@(posedge cfgClk) disable iff (!rstN)
    (rdAddr == CTRL_A) |-> ((rdData & ~LIVE_MASK) == '0)); // R3

  AST_LOCKED_WRITE: assert property (@(posedge cfgClk) disable iff (!rstN)
    (wrEn && wrAddr == CTRL_A && !wenBit) |=> ($stable(trigBit) && $stable(modeBit))); // R2

  AST_TRIG_KEPT: assert property (@(posedge cfgClk) disable iff (!rstN)
    (trigBit && !(wrEn && wrAddr == CTRL_A)) |=> trigBit); // R8

  AST_ONE_FIRE: assert property (@(posedge srcClk) disable iff (!rstN)
    fire |=> !fire); // R6

  AST_GATE_OPEN: assert property (@(negedge srcClk) disable iff (!rstN)
    (fire || runFree) |=> gateOn); // R10

  AST_GATE_SHUT: assert property (@(negedge srcClk) disable iff (!rstN)
    (!fire && !runFree) |=> !gateOn); // R5

endmodule

bind spTestClkGate spTestClkGateChk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .cfgClk (cfgClk),
  .srcClk (srcClk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .rdAddr (rdAddr),
  .rdData (rdData),
  .wenBit (wenBit),
  .trigBit(trigBit),
  .modeBit(modeBit),
  .fire   (fire),
  .runFree(runFree),
  .gateOn (gateOn)
);

// File: tb/spTestClkGate_tb.sv
`timescale 1ns/1ps
module spTestClkGate_tb;

  localparam realtime CLK_PERIOD = 8.0;
  localparam realtime CFG_PERIOD = 14.0;
  localparam realtime AUX_PERIOD = 10.0;
  localparam int      WIN        = 20;

  logic       cfgClk = 0, srcClk = 0, auxClkIn = 0, rstN = 0;
  logic       wrEn = 0;
  logic [3:0] wrAddr = 0, rdAddr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic       clkOutT, clkOutC, auxClkOut;

  int nChecks = 0, nFails = 0;
  int riseCnt = 0, auxCnt = 0, compBad = 0;
  realtime tRise = 0, hiWidth = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) srcClk = ~srcClk;
  always #(CFG_PERIOD/2) cfgClk = ~cfgClk;
  always #(AUX_PERIOD/2) auxClkIn = ~auxClkIn;

  spTestClkGate u_dut (
    .cfgClk(cfgClk), .srcClk(srcClk), .auxClkIn(auxClkIn), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .clkOutT(clkOutT), .clkOutC(clkOutC), .auxClkOut(auxClkOut)
  );

  always @(posedge clkOutT) begin riseCnt++; tRise = $realtime; end
  always @(negedge clkOutT) hiWidth = $realtime - tRise;
  always @(posedge auxClkOut) auxCnt++;
  always #(CLK_PERIOD/8) if (rstN && clkOutC !== ~clkOutT) compBad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge cfgClk);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge cfgClk);
    wrEn = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge cfgClk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic settle();
    repeat (16) @(posedge srcClk);
  endtask

  // Count rising edges of clkOutT and auxClkOut over WIN source periods
  task automatic window(output int rises, output int auxes);
    @(negedge srcClk); #1;
    riseCnt = 0; auxCnt = 0;
    #(WIN*CLK_PERIOD);
    rises = riseCnt; auxes = auxCnt;
  endtask

  task automatic testReset();
    logic [7:0] d;
    int r, a;
    regRead(4'd0, d); check(d == 8'h00, "R1 wen byte", d, 0);
    regRead(4'd8, d); check(d == 8'h00, "R1 ctrl byte", d, 0);
    settle();
    window(r, a); check(r == WIN, "R1 runs after reset", r, WIN);
  endtask

  task automatic testNormal();
    int r, a;
    compBad = 0;
    window(r, a);
    check(r == WIN, "R4 one edge per period", r, WIN);
    check(compBad == 0, "R4 complement inverse", compBad, 0);
    check(a >= 15 && a <= 17, "R9 aux runs normal", a, 16);
  endtask

  task automatic testLock();
    logic [7:0] d;
    int r, a;
    regWrite(4'd8, 8'h40);
    regRead(4'd8, d); check(d == 8'h00, "R2 locked write ignored", d, 0);
    settle();
    window(r, a); check(r == WIN, "R2 output still running", r, WIN);
    regWrite(4'd0, 8'h01);
    regRead(4'd0, d); check(d == 8'h01, "R2 wen set", d, 1);
    regWrite(4'd8, 8'h3F);
    regRead(4'd8, d); check(d == 8'h00, "R3 reserved read zero", d, 0);
  endtask

  task automatic testParked();
    logic [7:0] d;
    int r, a;
    regWrite(4'd8, 8'h40);
    regRead(4'd8, d); check(d == 8'h40, "R3 mode bit 6", d, 8'h40);
    settle();
    compBad = 0;
    window(r, a);
    check(r == 0, "R5 parked no edges", r, 0);
    check(clkOutT == 1'b0 && clkOutC == 1'b1, "R5 parked levels", {clkOutT, clkOutC}, 1);
    check(a >= 15 && a <= 17, "R9 aux runs parked", a, 16);
    check(compBad == 0, "R4 complement parked", compBad, 0);
  endtask

  task automatic testPulse(input string tag);
    int r, a;
    regWrite(4'd8, 8'h40);
    settle();
    @(negedge srcClk); riseCnt = 0; hiWidth = 0;
    regWrite(4'd8, 8'hC0);
    settle();
    check(riseCnt == 1, tag, riseCnt, 1);
    check(hiWidth > CLK_PERIOD/2 - 0.01 && hiWidth < CLK_PERIOD/2 + 0.01,
          "R6 pulse high half period", int'(hiWidth*1000), int'(CLK_PERIOD*500));
    window(r, a); check(r == 0, "R7 held trigger no more pulses", r, 0);
  endtask

  task automatic testKept();
    logic [7:0] d;
    regRead(4'd8, d); check(d == 8'hC0, "R8 trigger not cleared", d, 8'hC0);
  endtask

  task automatic testDropped();
    int r, a;
    logic [7:0] d;
    regWrite(4'd8, 8'h00);
    settle();
    regWrite(4'd8, 8'h80);
    settle();
    window(r, a); check(r == WIN, "R11 trigger with mode off runs", r, WIN);
    regWrite(4'd8, 8'hC0);
    settle();
    window(r, a); check(r == 0, "R11 mode on with trigger high no pulse", r, 0);
    regRead(4'd8, d); check(d == 8'hC0, "R8 readback", d, 8'hC0);
  endtask

  task automatic testLeave();
    int r, a;
    regWrite(4'd8, 8'h00);
    settle();
    compBad = 0;
    window(r, a);
    check(r == WIN, "R10 clean resume", r, WIN);
    check(compBad == 0, "R4 complement resume", compBad, 0);
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(3*CFG_PERIOD) rstN = 1;
    testReset();
    testNormal();
    testLock();
    testParked();
    testPulse("R6 single pulse");
    testKept();
    regWrite(4'd8, 8'h40);
    testPulse("R7 re-armed pulse");
    testDropped();
    testLeave();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule